// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time (seconds, minutes, hours, day of month, month, a two-digit year counted from 2000, and a free-running weekday) and shows every field as a BCD byte on a small byte-wide register port. It is clocked by the system clock and advanced by a single-cycle `osc_tick` strobe at the crystal rate. An internal prescaler of `PRESCALE` strobes makes one second. Once per `HOUR_SECS` seconds, the length of one second is corrected by a signed, software-set drift value.

Software stages new time fields by writing the time registers. It then writes an update command whose low nibble picks which staged fields are copied into the running clock. Before the copy, the staged values are range-checked, and a failed check raises an error pulse instead. A control byte starts and stops counting, arms the alarm, switches the hour display between 24-hour and 12-hour-with-PM-flag, and picks the rate of a periodic event. The periodic event, the alarm match and the update error each leave as a one-cycle pulse, to be collected by an external interrupt controller.

Top module: `bcd_rtc`

## Requirements
- R1: After reset, control and compensation read zero and all pulses are low. The clock reads 00:00:00 on day 01, month 01, year 00, weekday 0. The alarm reads 00:00:00 on day 01, month 01, year 04.
- R2: The control register is at offset 0x00. Bit 0 runs the clock, bit 1 arms the alarm, bit 2 selects 12-hour display and bits 4:3 pick the event rate. Bits 7:5 always read zero.
- R3: While running, every `PRESCALE`-th `osc_tick` ends a second. Seconds carry into minutes, minutes into hours, hours into day (weekday steps 0..6 with the day), day into month and month into year. Year 99 wraps to 00.
- R4: The day wraps after the last day of the month. February has 29 days when the year is a multiple of 4 and 28 days otherwise. April, June, September and November have 30 days; the other months have 31.
- R5: With bit 0 clear, `osc_tick` is ignored: the time fields and the prescaler hold their values and no event or alarm pulse occurs.
- R6: All fields read as BCD. In 24-hour mode, the hour at 0x04 reads 00..23. In 12-hour mode it reads 01..12, with bit 7 set for PM (midnight reads 0x12, noon 0x92). Hour writes are decoded in whichever mode is active.
- R7: Writes to sec 0x02, min 0x03, hour 0x04, day 0x05, month 0x06, year 0x07 and weekday 0x08 only stage values; reads return the live time. Seconds and minutes take the low 7 bits of the write. Command codes written to 0x01 commit fields: 1 sec, 2 min, 3 hour, 4 day, 5 month, 6 year, 7 weekday, 8 all but weekday, and 0 commits nothing.
- R8: A command is rejected if its code is 9..15 or if a field it would commit is out of range (sec or min above 59, hour above 23, day 0 or above 31, month 0 or above 12). A rejected command changes nothing and pulses `upd_err_pulse` in the cycle after the write.
- R9: The command register at 0x01 always reads 0x00.
- R10: On each completed second, `evt_pulse` fires for one cycle. With rate 0 it fires every second, with rate 1 when seconds become 00, with rate 2 when minutes and seconds become 00:00, and with rate 3 at 00:00:00.
- R11: The alarm fields (0x09 sec, 0x0A min, 0x0B hour, 0x0C day, 0x0D month, 0x0E year) read back in BCD. `alarm_pulse` fires for one cycle when bit 1 is set and a completed second makes the time equal to all six alarm fields.
- R12: Compensation is a signed 16-bit value (high byte 0x0F, low byte 0x10). The last second of every `HOUR_SECS` running seconds lasts `PRESCALE` minus that value in ticks, and never less than one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle strobe at the crystal rate |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register offset |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte for `addr` (combinational) |
| evt_pulse | output | 1 | Periodic event pulse |
| alarm_pulse | output | 1 | Alarm match pulse |
| upd_err_pulse | output | 1 | Rejected update command pulse |

## Verification
A wrong carry or month-length decision appears in the BCD read-back in the same second it happens, and a wrong periodic or alarm decision appears as a missing or extra one-cycle pulse on the tick that completes that second. A compensation error only shows at the hourly correction second, and then as a second that is too long or too short: the seconds field drifts from the expected value from that second on. A range-check or decode fault in the command path shows one cycle after the command write, either as `upd_err_pulse` or as a field that changed when it should not have.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

   localparam int CTRL_W   = 5;
   localparam int COMP_W   = 16;
   localparam int N_FIELDS = 6;

   localparam int CB_RUN  = 0;
   localparam int CB_ALM  = 1;
   localparam int CB_12H  = 2;
   localparam int CB_RATE = 3;

   localparam int A_CTRL  = 'h00;
   localparam int A_CMD   = 'h01;
   localparam int A_SEC   = 'h02;
   localparam int A_MIN   = 'h03;
   localparam int A_HOUR  = 'h04;
   localparam int A_DAY   = 'h05;
   localparam int A_MON   = 'h06;
   localparam int A_YEAR  = 'h07;
   localparam int A_WDAY  = 'h08;
   localparam int A_ASEC  = 'h09;
   localparam int A_AMIN  = 'h0A;
   localparam int A_AHOUR = 'h0B;
   localparam int A_ADAY  = 'h0C;
   localparam int A_AMON  = 'h0D;
   localparam int A_AYEAR = 'h0E;
   localparam int A_COMPH = 'h0F;
   localparam int A_COMPL = 'h10;

   typedef struct packed {
      logic [7:0] sec;
      logic [7:0] min;
      logic [7:0] hour;
      logic [7:0] day;
      logic [7:0] mon;
      logic [7:0] year;
   } rtc_time_t;

   localparam rtc_time_t TIME_RST  = '{sec: 8'd0, min: 8'd0, hour: 8'd0,
                                       day: 8'd1, mon: 8'd1, year: 8'd0};
   localparam rtc_time_t ALARM_RST = '{sec: 8'd0, min: 8'd0, hour: 8'd0,
                                       day: 8'd1, mon: 8'd1, year: 8'd4};

   function automatic logic [7:0] bcd2bin(input logic [7:0] v);
      return 8'({4'd0, v[7:4]} * 8'd10 + {4'd0, v[3:0]});
   endfunction

   function automatic logic [7:0] bin2bcd(input logic [7:0] b);
      logic [7:0] t, o;
      t = b / 8'd10;
      o = b % 8'd10;
      return {t[3:0], o[3:0]};
   endfunction

   function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
      case (m)
         8'd2:                     return (y[1:0] == 2'b00) ? 8'd29 : 8'd28;
         8'd4, 8'd6, 8'd9, 8'd11:  return 8'd30;
         default:                  return 8'd31;
      endcase
   endfunction

   function automatic logic [7:0] hour_to_reg(input logic [7:0] h, input logic mode12);
      if (!mode12)        return bin2bcd(h);
      else if (h == 8'd0) return 8'h12;
      else if (h < 8'd12) return bin2bcd(h);
      else if (h == 8'd12) return 8'h92;
      else                return 8'h80 | bin2bcd(h - 8'd12);
   endfunction

   function automatic logic [7:0] reg_to_hour(input logic [7:0] v, input logic mode12);
      logic [7:0] h12;
      if (!mode12) return bcd2bin(v & 8'h3F);
      h12 = bcd2bin({3'b000, v[4:0]});
      if (h12 == 8'd0 || h12 > 8'd12) return 8'd31;
      return ((h12 == 8'd12) ? 8'd0 : h12) + (v[7] ? 8'd12 : 8'd0);
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int PRESCALE  = 32768,
   parameter int HOUR_SECS = 3600
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        run,
   input  logic        osc_tick,
   input  logic [15:0] comp,
   output logic        sec_step
);
   localparam int CNT_W = $clog2(PRESCALE + 32769);
   localparam int HC_W  = (HOUR_SECS > 1) ? $clog2(HOUR_SECS) : 1;

   logic [CNT_W-1:0] cnt;
   logic [HC_W-1:0]  hcnt;
   logic             hour_due;
   logic             last;
   int               lim;

   assign hour_due = (int'(hcnt) == HOUR_SECS - 1);

   always_comb begin
      lim = PRESCALE;
      if (hour_due) lim = PRESCALE - int'($signed(comp));
      if (lim < 1) lim = 1;
   end

   assign last     = (int'(cnt) + 1 >= lim);
   assign sec_step = run & osc_tick & last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         hcnt <= '0;
      end else begin
         if (run && osc_tick) begin
            if (last) cnt <= '0;
            else      cnt <= cnt + 1'b1;
         end
         if (sec_step) hcnt <= hour_due ? '0 : hcnt + 1'b1;
      end
   end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
   import bcd_rtc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      step,
   input  logic      commit,
   input  logic [6:0] commit_mask,
   input  rtc_time_t stg,
   input  logic [7:0] stg_wday,
   output rtc_time_t cur,
   output logic [7:0] cur_wday,
   output rtc_time_t nxt
);
   logic [7:0] mlen;
   logic       s_w, m_w, h_w, d_w, mo_w;
   logic [7:0] nxt_wday;

   always_comb begin
      mlen = month_len(cur.mon, cur.year);
      s_w  = cur.sec >= 8'd59;
      m_w  = s_w && cur.min >= 8'd59;
      h_w  = m_w && cur.hour >= 8'd23;
      d_w  = h_w && cur.day >= mlen;
      mo_w = d_w && cur.mon >= 8'd12;
      nxt.sec  = s_w  ? 8'd0 : cur.sec + 8'd1;
      nxt.min  = m_w  ? 8'd0 : (s_w ? cur.min + 8'd1 : cur.min);
      nxt.hour = h_w  ? 8'd0 : (m_w ? cur.hour + 8'd1 : cur.hour);
      nxt.day  = d_w  ? 8'd1 : (h_w ? cur.day + 8'd1 : cur.day);
      nxt.mon  = mo_w ? 8'd1 : (d_w ? cur.mon + 8'd1 : cur.mon);
      nxt.year = mo_w ? ((cur.year >= 8'd99) ? 8'd0 : cur.year + 8'd1) : cur.year;
      nxt_wday = h_w  ? ((cur_wday >= 8'd6) ? 8'd0 : cur_wday + 8'd1) : cur_wday;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur      <= TIME_RST;
         cur_wday <= 8'd0;
      end else if (commit) begin
         if (commit_mask[0]) cur.sec  <= stg.sec;
         if (commit_mask[1]) cur.min  <= stg.min;
         if (commit_mask[2]) cur.hour <= stg.hour;
         if (commit_mask[3]) cur.day  <= stg.day;
         if (commit_mask[4]) cur.mon  <= stg.mon;
         if (commit_mask[5]) cur.year <= stg.year;
         if (commit_mask[6]) cur_wday <= stg_wday;
      end else if (step) begin
         cur      <= nxt;
         cur_wday <= nxt_wday;
      end
   end
endmodule

// File: rtl/rtc_events.sv
module rtc_events
   import bcd_rtc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      step,
   input  logic [1:0] rate,
   input  logic      alm_en,
   input  rtc_time_t nxt,
   input  rtc_time_t alarm,
   output logic      evt_pulse,
   output logic      alarm_pulse
);
   logic [N_FIELDS-1:0][7:0] n_arr, a_arr;
   logic [N_FIELDS-1:0]      eq;
   logic                     evt_hit;

   assign n_arr = nxt;
   assign a_arr = alarm;

   for (genvar i = 0; i < N_FIELDS; i++) begin : g_cmp
      assign eq[i] = (n_arr[i] == a_arr[i]);
   end

   always_comb begin
      case (rate)
         2'd0:    evt_hit = 1'b1;
         2'd1:    evt_hit = (nxt.sec == 8'd0);
         2'd2:    evt_hit = (nxt.sec == 8'd0) && (nxt.min == 8'd0);
         default: evt_hit = (nxt.sec == 8'd0) && (nxt.min == 8'd0) && (nxt.hour == 8'd0);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_pulse   <= 1'b0;
         alarm_pulse <= 1'b0;
      end else begin
         evt_pulse   <= step && evt_hit;
         alarm_pulse <= step && alm_en && (&eq);
      end
   end
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
   import bcd_rtc_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wr_data,
   output logic [7:0]        rd_data,
   input  rtc_time_t         cur,
   input  logic [7:0]        cur_wday,
   output logic [CTRL_W-1:0] ctrl,
   output logic [COMP_W-1:0] comp,
   output rtc_time_t         alarm,
   output rtc_time_t         stg,
   output logic [7:0]        stg_wday,
   output logic              commit,
   output logic [6:0]        commit_mask,
   output logic              upd_err
);
   logic       in_map;
   logic [4:0] a;
   logic       mode12;
   logic       cmd_wr;
   logic       cmd_ok;
   logic [6:0] f_ok;
   logic [3:0] code;

   assign in_map = ((addr >> 5) == '0);
   assign a      = addr[4:0];
   assign mode12 = ctrl[CB_12H];
   assign cmd_wr = wr_en && in_map && (a == 5'(A_CMD));
   assign code   = wr_data[3:0];

   always_comb begin
      f_ok[0] = stg.sec  < 8'd60;
      f_ok[1] = stg.min  < 8'd60;
      f_ok[2] = stg.hour < 8'd24;
      f_ok[3] = (stg.day >= 8'd1) && (stg.day <= 8'd31);
      f_ok[4] = (stg.mon >= 8'd1) && (stg.mon <= 8'd12);
      f_ok[5] = stg.year < 8'd100;
      f_ok[6] = stg_wday < 8'd7;
      cmd_ok      = 1'b0;
      commit_mask = '0;
      if (code == 4'd0) begin
         cmd_ok = 1'b1;
      end else if (code <= 4'd7) begin
         cmd_ok      = f_ok[code - 4'd1];
         commit_mask = 7'(1) << (code - 4'd1);
      end else if (code == 4'd8) begin
         cmd_ok      = &f_ok[5:0];
         commit_mask = 7'h3F;
      end
   end

   assign commit = cmd_wr && cmd_ok && (|commit_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl     <= '0;
         comp     <= '0;
         alarm    <= ALARM_RST;
         stg      <= TIME_RST;
         stg_wday <= 8'd0;
         upd_err  <= 1'b0;
      end else begin
         upd_err <= cmd_wr && !cmd_ok;
         if (wr_en && in_map) begin
            case (a)
               5'(A_CTRL):  ctrl       <= wr_data[CTRL_W-1:0];
               5'(A_SEC):   stg.sec    <= bcd2bin(wr_data & 8'h7F);
               5'(A_MIN):   stg.min    <= bcd2bin(wr_data & 8'h7F);
               5'(A_HOUR):  stg.hour   <= reg_to_hour(wr_data, mode12);
               5'(A_DAY):   stg.day    <= bcd2bin(wr_data);
               5'(A_MON):   stg.mon    <= bcd2bin(wr_data);
               5'(A_YEAR):  stg.year   <= bcd2bin(wr_data);
               5'(A_WDAY):  stg_wday   <= bcd2bin(wr_data);
               5'(A_ASEC):  alarm.sec  <= bcd2bin(wr_data & 8'h7F);
               5'(A_AMIN):  alarm.min  <= bcd2bin(wr_data & 8'h7F);
               5'(A_AHOUR): alarm.hour <= reg_to_hour(wr_data, mode12);
               5'(A_ADAY):  alarm.day  <= bcd2bin(wr_data);
               5'(A_AMON):  alarm.mon  <= bcd2bin(wr_data);
               5'(A_AYEAR): alarm.year <= bcd2bin(wr_data);
               5'(A_COMPH): comp[15:8] <= wr_data;
               5'(A_COMPL): comp[7:0]  <= wr_data;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      rd_data = 8'h00;
      if (in_map) begin
         case (a)
            5'(A_CTRL):  rd_data = {{(8-CTRL_W){1'b0}}, ctrl};
            5'(A_SEC):   rd_data = bin2bcd(cur.sec);
            5'(A_MIN):   rd_data = bin2bcd(cur.min);
            5'(A_HOUR):  rd_data = hour_to_reg(cur.hour, mode12);
            5'(A_DAY):   rd_data = bin2bcd(cur.day);
            5'(A_MON):   rd_data = bin2bcd(cur.mon);
            5'(A_YEAR):  rd_data = bin2bcd(cur.year);
            5'(A_WDAY):  rd_data = bin2bcd(cur_wday);
            5'(A_ASEC):  rd_data = bin2bcd(alarm.sec);
            5'(A_AMIN):  rd_data = bin2bcd(alarm.min);
            5'(A_AHOUR): rd_data = hour_to_reg(alarm.hour, mode12);
            5'(A_ADAY):  rd_data = bin2bcd(alarm.day);
            5'(A_AMON):  rd_data = bin2bcd(alarm.mon);
            5'(A_AYEAR): rd_data = bin2bcd(alarm.year);
            5'(A_COMPH): rd_data = comp[15:8];
            5'(A_COMPL): rd_data = comp[7:0];
            default:     rd_data = 8'h00;
         endcase
      end
   end
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
   import bcd_rtc_pkg::*;
#(
   parameter int PRESCALE  = 32768,
   parameter int HOUR_SECS = 3600,
   parameter int ADDR_W    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wr_data,
   output logic [7:0]        rd_data,
   output logic              evt_pulse,
   output logic              alarm_pulse,
   output logic              upd_err_pulse
);
   if (PRESCALE < 2) begin : g_bad_prescale
      $error("PRESCALE must be at least 2");
   end
   if (HOUR_SECS < 1) begin : g_bad_hour
      $error("HOUR_SECS must be at least 1");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must be at least 5");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic [COMP_W-1:0] comp_q;
   rtc_time_t         alarm_q, stg_q, cur_time, nxt_time;
   logic [7:0]        stg_wday, cur_wday;
   logic              commit;
   logic [6:0]        commit_mask;
   logic              sec_step;

   rtc_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .rd_data(rd_data), .cur(cur_time), .cur_wday(cur_wday), .ctrl(ctrl_q),
      .comp(comp_q), .alarm(alarm_q), .stg(stg_q), .stg_wday(stg_wday),
      .commit(commit), .commit_mask(commit_mask), .upd_err(upd_err_pulse)
   );

   rtc_prescaler #(.PRESCALE(PRESCALE), .HOUR_SECS(HOUR_SECS)) u_presc (
      .clk(clk), .rst_n(rst_n), .run(ctrl_q[CB_RUN]), .osc_tick(osc_tick),
      .comp(comp_q), .sec_step(sec_step)
   );

   rtc_time_core u_core (
      .clk(clk), .rst_n(rst_n), .step(sec_step), .commit(commit),
      .commit_mask(commit_mask), .stg(stg_q), .stg_wday(stg_wday),
      .cur(cur_time), .cur_wday(cur_wday), .nxt(nxt_time)
   );

   rtc_events u_evt (
      .clk(clk), .rst_n(rst_n), .step(sec_step && !commit),
      .rate(ctrl_q[CB_RATE+1:CB_RATE]), .alm_en(ctrl_q[CB_ALM]),
      .nxt(nxt_time), .alarm(alarm_q), .evt_pulse(evt_pulse),
      .alarm_pulse(alarm_pulse)
   );
endmodule

// File: rtl/bcd_rtc_checker.sv
module bcd_rtc_checker
   import bcd_rtc_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        wr_data,
   input logic [7:0]        rd_data,
   input logic [CTRL_W-1:0] ctrl,
   input rtc_time_t         cur,
   input logic              alarm_pulse,
   input logic              upd_err_pulse
);
   assert_cmd_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(A_CMD)) |-> (rd_data == 8'h00));

   assert_ctrl_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(A_CTRL)) |-> (rd_data[7:5] == 3'b000));

   assert_time_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cur.sec < 8'd60) && (cur.min < 8'd60) && (cur.hour < 8'd24) && (cur.year < 8'd100));

   assert_date_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cur.day >= 8'd1) && (cur.day <= 8'd31) && (cur.mon >= 8'd1) && (cur.mon <= 8'd12));

   assert_stop_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl[CB_RUN] && !(wr_en && addr == ADDR_W'(A_CMD))) |=> $stable(cur));

   assert_bad_code_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(A_CMD) && wr_data[3:0] > 4'd8) |=> upd_err_pulse);

   assert_alarm_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_pulse |-> $past(ctrl[CB_ALM]));
endmodule

bind bcd_rtc bcd_rtc_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
   .rd_data(rd_data), .ctrl(ctrl_q), .cur(cur_time),
   .alarm_pulse(alarm_pulse), .upd_err_pulse(upd_err_pulse)
);

// File: tb/bcd_rtc_tb_top.sv
`timescale 1ns/1ps
module bcd_rtc_tb_top;
   localparam int PS = 4;
   localparam int HS = 20;
   localparam int AW = 6;

   logic clk = 1'b0, rst_n = 1'b0, osc_tick = 1'b0, wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic evt_pulse, alarm_pulse, upd_err_pulse;

   int n_tests = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   bcd_rtc #(.PRESCALE(PS), .HOUR_SECS(HS), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .evt_pulse(evt_pulse),
      .alarm_pulse(alarm_pulse), .upd_err_pulse(upd_err_pulse));

   // bench model
   int m_sec = 0, m_min = 0, m_hr = 0, m_day = 1, m_mon = 1, m_yr = 0, m_wd = 0;
   int a_sec = 0, a_min = 0, a_hr = 0, a_day = 1, a_mon = 1, a_yr = 4;
   int s_sec = 0, s_min = 0, s_hr = 0, s_day = 1, s_mon = 1, s_yr = 0, s_wd = 0;
   int pcnt = 0, hcnt = 0, comp = 0, rate = 0;
   bit run = 0, aen = 0, m12 = 0;

   function automatic int bcd(int v); return (v / 10) * 16 + (v % 10); endfunction
   function automatic int unbcd(int v); return ((v >> 4) & 15) * 10 + (v & 15); endfunction
   function automatic int mlen(int m, int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction
   function automatic int hreg(int h, bit mode);
      if (!mode) return bcd(h);
      if (h == 0) return 'h12;
      if (h < 12) return bcd(h);
      if (h == 12) return 'h92;
      return 'h80 | bcd(h - 12);
   endfunction

   task automatic advance();
      bit hw;
      hw = 0;
      m_sec++;
      if (m_sec == 60) begin
         m_sec = 0; m_min++;
         if (m_min == 60) begin
            m_min = 0; m_hr++;
            if (m_hr == 24) begin m_hr = 0; hw = 1; end
         end
      end
      if (hw) begin
         m_wd = (m_wd + 1) % 7;
         m_day++;
         if (m_day > mlen(m_mon, m_yr)) begin
            m_day = 1; m_mon++;
            if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
         end
      end
   endtask

   task automatic check(string req, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(int a, int d);
      wr_en = 1'b1; addr = AW'(a); wr_data = 8'(d);
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(int a, output int d);
      addr = AW'(a); #1; d = int'(rd_data);
   endtask

   task automatic chk_reg(string req, int a, int exp);
      int d;
      rd(a, d);
      check(req, d, exp);
   endtask

   task automatic chk_time(string req);
      chk_reg(req, 'h02, bcd(m_sec));
      chk_reg(req, 'h03, bcd(m_min));
      chk_reg(req, 'h04, hreg(m_hr, m12));
      chk_reg(req, 'h05, bcd(m_day));
      chk_reg(req, 'h06, bcd(m_mon));
      chk_reg(req, 'h07, bcd(m_yr));
      chk_reg(req, 'h08, bcd(m_wd));
   endtask

   task automatic wr_ctrl(int v);
      wr('h00, v);
      run = v[0]; aen = v[1]; m12 = v[2]; rate = (v >> 3) & 3;
   endtask

   task automatic wr_comp(int v);
      wr('h0F, (v >> 8) & 255);
      wr('h10, v & 255);
      comp = (v & 'h8000) ? (v & 'hFFFF) - 'h10000 : (v & 'hFFFF);
   endtask

   // issue a command; expected rejection derived from the staged model values
   task automatic cmd(int code, string req);
      bit ok;
      bit f0, f1, f2, f3, f4, f5, f6;
      f0 = s_sec < 60; f1 = s_min < 60; f2 = s_hr < 24;
      f3 = s_day >= 1 && s_day <= 31; f4 = s_mon >= 1 && s_mon <= 12;
      f5 = s_yr < 100; f6 = s_wd < 7;
      case (code)
         0: ok = 1;  1: ok = f0;  2: ok = f1;  3: ok = f2;  4: ok = f3;
         5: ok = f4; 6: ok = f5;  7: ok = f6;
         8: ok = f0 && f1 && f2 && f3 && f4 && f5;
         default: ok = 0;
      endcase
      wr('h01, code);
      check({req, " err pulse"}, int'(upd_err_pulse), ok ? 0 : 1);
      if (ok) begin
         if (code == 1 || code == 8) m_sec = s_sec;
         if (code == 2 || code == 8) m_min = s_min;
         if (code == 3 || code == 8) m_hr  = s_hr;
         if (code == 4 || code == 8) m_day = s_day;
         if (code == 5 || code == 8) m_mon = s_mon;
         if (code == 6 || code == 8) m_yr  = s_yr;
         if (code == 7) m_wd = s_wd;
      end
   endtask

   task automatic stage24(int y, int mo, int d, int h, int mi, int s, int wd);
      wr('h02, bcd(s));  s_sec = s;
      wr('h03, bcd(mi)); s_min = mi;
      wr('h04, bcd(h));  s_hr = h;
      wr('h05, bcd(d));  s_day = d;
      wr('h06, bcd(mo)); s_mon = mo;
      wr('h07, bcd(y));  s_yr = y;
      wr('h08, bcd(wd)); s_wd = wd;
   endtask

   task automatic set_time(int y, int mo, int d, int h, int mi, int s, int wd);
      wr_ctrl(0);
      stage24(y, mo, d, h, mi, s, wd);
      cmd(8, "R7");
      cmd(7, "R7");
   endtask

   task automatic set_alarm(int y, int mo, int d, int h, int mi, int s);
      wr('h09, bcd(s));  a_sec = s;
      wr('h0A, bcd(mi)); a_min = mi;
      wr('h0B, hreg(h, m12)); a_hr = h;
      wr('h0C, bcd(d));  a_day = d;
      wr('h0D, bcd(mo)); a_mon = mo;
      wr('h0E, bcd(y));  a_yr = y;
   endtask

   task automatic tick();
      int  lim;
      bit  e_evt, e_alm;
      osc_tick = 1'b1;
      @(posedge clk); #1;
      osc_tick = 1'b0;
      e_evt = 0; e_alm = 0;
      if (run) begin
         pcnt++;
         lim = (hcnt == HS - 1) ? PS - comp : PS;
         if (lim < 1) lim = 1;
         if (pcnt >= lim) begin
            pcnt = 0;
            hcnt = (hcnt == HS - 1) ? 0 : hcnt + 1;
            advance();
            case (rate)
               0: e_evt = 1;
               1: e_evt = (m_sec == 0);
               2: e_evt = (m_sec == 0 && m_min == 0);
               default: e_evt = (m_sec == 0 && m_min == 0 && m_hr == 0);
            endcase
            e_alm = aen && m_sec == a_sec && m_min == a_min && m_hr == a_hr &&
                    m_day == a_day && m_mon == a_mon && m_yr == a_yr;
         end
      end
      check("R10 event pulse", int'(evt_pulse), int'(e_evt));
      check("R11 alarm pulse", int'(alarm_pulse), int'(e_alm));
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int d;
      #1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 evt", int'(evt_pulse), 0);
      check("R1 alarm", int'(alarm_pulse), 0);
      check("R1 err", int'(upd_err_pulse), 0);
      chk_reg("R1 ctrl", 'h00, 0);
      chk_reg("R1 comp hi", 'h0F, 0);
      chk_reg("R1 comp lo", 'h10, 0);
      chk_time("R1 time");
      chk_reg("R1 alarm sec", 'h09, 0);
      chk_reg("R1 alarm hour", 'h0B, 0);
      chk_reg("R1 alarm day", 'h0C, 'h01);
      chk_reg("R1 alarm mon", 'h0D, 'h01);
      chk_reg("R1 alarm year", 'h0E, 'h04);

      // R2 control width
      wr('h00, 'hFA);
      chk_reg("R2 ctrl mask", 'h00, 'h1A);
      wr_ctrl(0);

      // R5 stopped clock ignores ticks
      ticks(3 * PS);
      chk_time("R5 stopped");

      // R3 carries, year wrap, weekday wrap
      set_time(99, 12, 31, 23, 59, 58, 6);
      wr_ctrl('h01);
      ticks(3 * PS);
      chk_time("R3 year wrap");

      // R4 leap and non-leap February
      set_time(4, 2, 28, 23, 59, 59, 0);
      wr_ctrl('h01);
      ticks(PS);
      chk_time("R4 leap 29th");
      set_time(1, 2, 28, 23, 59, 59, 0);
      wr_ctrl('h01);
      ticks(PS);
      chk_time("R4 non-leap march");
      set_time(3, 4, 30, 23, 59, 59, 2);
      wr_ctrl('h01);
      ticks(PS);
      chk_time("R4 thirty-day month");

      // R6 12-hour presentation and writes
      set_time(10, 6, 15, 0, 30, 0, 1);
      wr_ctrl('h04);
      chk_time("R6 midnight 12h");
      wr('h04, 'h81); s_hr = 13;
      cmd(3, "R6");
      chk_time("R6 1pm 12h");
      wr('h04, 'h92); s_hr = 12;
      cmd(3, "R6");
      chk_reg("R6 noon", 'h04, 'h92);
      wr('h0B, 'h12); a_hr = 0;
      wr_ctrl(0);
      chk_reg("R6 noon 24h", 'h04, 'h12);
      chk_reg("R6 alarm midnight 24h", 'h0B, 'h00);

      // R7 staging and partial commit
      stage24(20, 3, 9, 8, 7, 6, 5);
      chk_time("R7 staging invisible");
      cmd(0, "R7");
      chk_time("R7 code 0");
      cmd(2, "R7");
      chk_time("R7 minute only");
      cmd(5, "R7");
      chk_time("R7 month only");
      wr('h02, 'hD9); s_sec = 59;
      cmd(1, "R7");
      chk_time("R7 sec low 7 bits");

      // R8 rejections
      wr('h04, 'h24); s_hr = 24;
      cmd(3, "R8");
      chk_time("R8 hour 24");
      wr('h05, 'h00); s_day = 0;
      cmd(4, "R8");
      chk_time("R8 day 0");
      wr('h05, 'h12); s_day = 12;
      wr('h06, 'h13); s_mon = 13;
      cmd(8, "R8");
      chk_time("R8 month 13 all");
      wr('h06, 'h00); s_mon = 0;
      cmd(5, "R8");
      cmd(9, "R8");
      cmd(15, "R8");
      chk_time("R8 bad code");
      wr('h06, 'h07); s_mon = 7;

      // R9 command reads zero
      wr('h01, 'h00);
      chk_reg("R9 cmd read", 'h01, 0);

      // R10 event rates
      for (int r = 0; r < 4; r++) begin
         set_time(50, 6, 30, 23, 59, 57, 3);
         wr_ctrl(1 | (r << 3));
         ticks(4 * PS);
         chk_time("R10 after rate run");
      end

      // R11 alarm armed and disarmed
      set_time(12, 5, 5, 10, 0, 0, 4);
      set_alarm(12, 5, 5, 10, 0, 3);
      chk_reg("R11 alarm sec rb", 'h09, 'h03);
      wr_ctrl('h03);
      ticks(5 * PS);
      set_time(12, 5, 5, 10, 0, 0, 4);
      wr_ctrl('h01);
      ticks(5 * PS);

      // R12 compensation
      wr_comp(2);
      chk_reg("R12 comp lo", 'h10, 2);
      wr_ctrl('h01);
      ticks(2 * HS * PS);
      chk_time("R12 positive");
      wr_comp(-3);
      chk_reg("R12 comp hi", 'h0F, 'hFF);
      wr_ctrl('h01);
      ticks(2 * HS * PS + 10);
      chk_time("R12 negative");
      wr_comp(10);
      wr_ctrl('h01);
      ticks(2 * HS * PS);
      chk_time("R12 clamp");

      // constrained random runs
      void'($urandom(32'd1234));
      for (int it = 0; it < 25; it++) begin
         int y, mo, dd, h, mi, s, wd, k, cv;
         int sv_s, sv_mi, sv_h, sv_d, sv_mo, sv_y, sv_w;
         y  = $urandom_range(99, 0);
         mo = $urandom_range(12, 1);
         dd = ($urandom_range(1, 0) == 1) ? mlen(mo, y) : $urandom_range(mlen(mo, y), 1);
         h  = ($urandom_range(1, 0) == 1) ? 23 : $urandom_range(23, 0);
         mi = ($urandom_range(1, 0) == 1) ? 59 : $urandom_range(59, 0);
         s  = $urandom_range(59, 45);
         wd = $urandom_range(6, 0);
         set_time(y, mo, dd, h, mi, s, wd);
         sv_s = m_sec; sv_mi = m_min; sv_h = m_hr; sv_d = m_day;
         sv_mo = m_mon; sv_y = m_yr; sv_w = m_wd;
         k = $urandom_range(8, 1);
         for (int j = 0; j < k; j++) advance();
         set_alarm(m_yr, m_mon, m_day, m_hr, m_min, m_sec);
         m_sec = sv_s; m_min = sv_mi; m_hr = sv_h; m_day = sv_d;
         m_mon = sv_mo; m_yr = sv_y; m_wd = sv_w;
         cv = $urandom_range(6, 0) - 3;
         wr_comp(cv);
         wr_ctrl(1 | ($urandom_range(1, 0) << 1) | ($urandom_range(1, 0) << 2) |
                 ($urandom_range(3, 0) << 3));
         ticks($urandom_range(60, 1));
         chk_time("R3 random");
         rd('h0B, d);
         check("R11 random alarm hour rb", d, hreg(a_hr, m12));
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule